// File: doc/BRIEF.md
# Transmit FIFO Host Port

This block is the host-facing side of a transmit path. It holds two synchronous FIFOs. One carries outgoing data words from the host toward the transmitter. The other carries completion status words from the transmitter back to the host. The host reaches both through a small register-style bus with an address, a write strobe, a read strobe and 32-bit data lanes. The transmitter side sees the data FIFO as a valid/ready source. It sees the status FIFO as a valid/ready sink.

Any write that lands anywhere in the data window pushes into the data FIFO, so software can stream words with incrementing addresses. Status words can be read in two ways. A popping read removes the entry. A peeking read leaves the FIFO untouched. A fixed read-only pattern lets the host detect its byte ordering.

In 16-bit bus mode, each half-word write in the window supplies one half of an entry, low half first. The entry is pushed when the second half arrives. Occupancy counts and a sticky overrun flag are brought out as outputs.

Top module: `txFifoHostPort`

## Requirements
- R1: After reset both levels read 0, `overrunFlag` is 0, `hostRdData` is 0, `dataOutValid` is 0 and `stsInReady` is 1.
- R2: A read with `hostAddr[7:2]` equal to 10h (offset 40h) returns the oldest status entry on `hostRdData` in the cycle after the read strobe, and it removes that entry (`stsLevel` drops by one).
- R3: A read with `hostAddr[7:2]` equal to 11h (offset 44h) returns the oldest status entry and leaves `stsLevel` and the FIFO contents unchanged.
- R4: A pop or peek read of an empty status FIFO returns 0, and `stsLevel` stays 0.
- R5: With `busMode16`=0, every write whose address lies from 20h to 3Fh inclusive pushes `hostWrData` as one entry. Entries leave at `dataOutData` in write order.
- R6: With `busMode16`=1, writes in the same window pair up. The first write supplies entry bits 15:0 and the second write supplies bits 31:16, both taken from `hostWrData[15:0]`. One entry is pushed when the second write arrives. In 32-bit mode a window write discards any pending half.
- R7: A read with `hostAddr[7:2]` equal to 19h (offset 64h) returns 87654321h.
- R8: A data push attempted while `dataLevel` is 16 is dropped and sets `overrunFlag`. The flag then stays 1 until reset.
- R9: `stsLevel` and `dataLevel` give the occupancy from 0 to 16. A status push with `stsInValid` is taken only while `stsInReady` (level below 16) is high.
- R10: Reads of the data window or of any unmapped address return 0. Writes to offsets 40h, 44h and 64h change no level, no entry and no flag.
- R11: `dataOutValid` is high whenever the data FIFO is non-empty. One entry is removed at each clock edge where `dataOutValid` and `dataOutReady` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busMode16 | input | 1 | 1 selects half-word pairing in the data window |
| hostAddr | input | 8 | Host byte address |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, registered on the read strobe |
| stsInValid | input | 1 | Transmitter offers a status word |
| stsInData | input | 32 | Status word from the transmitter |
| stsInReady | output | 1 | Status FIFO has room |
| dataOutValid | output | 1 | Data FIFO has an entry |
| dataOutData | output | 32 | Oldest data entry |
| dataOutReady | input | 1 | Transmitter takes the oldest entry |
| stsLevel | output | 5 | Status FIFO occupancy |
| dataLevel | output | 5 | Data FIFO occupancy |
| overrunFlag | output | 1 | Sticky data-FIFO overrun indicator |

## Verification
Directed sequences cover several patterns. Data writes go to the window edges and to unaligned addresses, which separates window decoding from exact address matching. A fill to 16 followed by one more write separates a dropped push from a wrapped pointer. A peek-peek-pop order on a few status words shows whether the peek path disturbs the FIFO. Reads of an empty FIFO catch underflow.

Half-word pairs with distinct low and high values show whether the halves are swapped or a lone half is pushed. Long random runs mix all address classes, both bus modes and simultaneous push and pop on both FIFOs. These runs check the ordering and level arithmetic under contention, with results compared against queue models in the bench.

// File: rtl/txp_pkg.sv
package txp_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam logic [WORD_W-1:0] BYTE_TEST_VALUE = 32'h8765_4321;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_POP  = 2'd1,
    RD_PEEK = 2'd2,
    RD_TEST = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic              dataPush;
    logic [WORD_W-1:0] dataWord;
    logic              stsPop;
    logic              rdEn;
    rdSel_e            rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/txpFifo.sv
module txpFifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popReq,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic pushAcc, popAcc;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign pushAcc  = pushReq && !full;
  assign popAcc   = popReq && !empty;
  assign headData = mem[rdPtr];
  assign level    = count;

  always_ff @(posedge clk) begin
    if (pushAcc) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushAcc) wrPtr <= nextPtr(wrPtr);
      if (popAcc)  rdPtr <= nextPtr(rdPtr);
      case ({pushAcc, popAcc})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && empty && !pushReq) |=> (count == '0));

  // R8
  full_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && full && !popReq) |=> (count == CNT_W'(DEPTH)));

  // R2
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !empty && !pushReq) |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/txpCtrl.sv
module txpCtrl
  import txp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMode16,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [WORD_W-1:0] hostWrData,
  output ctrlStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] WIN_FIRST = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] WIN_LAST  = ADDR_W'(8'h3F);
  localparam logic [ADDR_W-1:0] POP_OFF   = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] PEEK_OFF  = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] TEST_OFF  = ADDR_W'(8'h64);

  logic inWin, popHit, peekHit, testHit;
  logic halfPending;
  logic [HALF_W-1:0] lowHalf;

  assign inWin   = (hostAddr >= WIN_FIRST) && (hostAddr <= WIN_LAST);
  assign popHit  = hostAddr[ADDR_W-1:2] == POP_OFF[ADDR_W-1:2];
  assign peekHit = hostAddr[ADDR_W-1:2] == PEEK_OFF[ADDR_W-1:2];
  assign testHit = hostAddr[ADDR_W-1:2] == TEST_OFF[ADDR_W-1:2];

  always_comb begin
    strobes = '0;
    if (hostWr && inWin) begin
      if (!busMode16) begin
        strobes.dataPush = 1'b1;
        strobes.dataWord = hostWrData;
      end else if (halfPending) begin
        strobes.dataPush = 1'b1;
        strobes.dataWord = {hostWrData[HALF_W-1:0], lowHalf};
      end
    end
    if (hostRd) begin
      strobes.rdEn = 1'b1;
      if (popHit) begin
        strobes.rdSel  = RD_POP;
        strobes.stsPop = 1'b1;
      end else if (peekHit) begin
        strobes.rdSel = RD_PEEK;
      end else if (testHit) begin
        strobes.rdSel = RD_TEST;
      end else begin
        strobes.rdSel = RD_ZERO;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfPending <= 1'b0;
      lowHalf     <= '0;
    end else if (hostWr && inWin) begin
      if (busMode16) begin
        halfPending <= !halfPending;
        if (!halfPending) lowHalf <= hostWrData[HALF_W-1:0];
      end else begin
        halfPending <= 1'b0;
      end
    end
  end

  // R6
  half_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && inWin && busMode16 && !halfPending) |=> halfPending);
endmodule

// File: rtl/txpDatapath.sv
module txpDatapath
  import txp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              stsInValid,
  input  logic [WORD_W-1:0] stsInData,
  output logic              stsInReady,
  output logic              dataOutValid,
  output logic [WORD_W-1:0] dataOutData,
  input  logic              dataOutReady,
  output logic [LVL_W-1:0]  stsLevel,
  output logic [LVL_W-1:0]  dataLevel,
  output logic              overrunFlag,
  output logic [WORD_W-1:0] hostRdData
);
  logic stsEmpty, stsFull, dataEmpty, dataFull;
  logic [WORD_W-1:0] stsHead;

  txpFifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) dataFifo (
    .clk, .rstN,
    .pushReq (strobes.dataPush),
    .pushData(strobes.dataWord),
    .popReq  (dataOutReady),
    .headData(dataOutData),
    .empty   (dataEmpty),
    .full    (dataFull),
    .level   (dataLevel)
  );

  txpFifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) stsFifo (
    .clk, .rstN,
    .pushReq (stsInValid),
    .pushData(stsInData),
    .popReq  (strobes.stsPop),
    .headData(stsHead),
    .empty   (stsEmpty),
    .full    (stsFull),
    .level   (stsLevel)
  );

  assign dataOutValid = !dataEmpty;
  assign stsInReady   = !stsFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrunFlag <= 1'b0;
      hostRdData  <= '0;
    end else begin
      if (strobes.dataPush && dataFull) overrunFlag <= 1'b1;
      if (strobes.rdEn) begin
        case (strobes.rdSel)
          RD_POP, RD_PEEK: hostRdData <= stsEmpty ? '0 : stsHead;
          RD_TEST:         hostRdData <= BYTE_TEST_VALUE;
          default:         hostRdData <= '0;
        endcase
      end
    end
  end

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag |=> overrunFlag);

  // R3
  peek_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdEn && strobes.rdSel == RD_PEEK && !stsInValid) |=> $stable(stsLevel));

  // R11
  drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOutValid && dataOutReady && !strobes.dataPush) |=> (dataLevel == $past(dataLevel) - LVL_W'(1)));
endmodule

// File: rtl/txFifoHostPort.sv
module txFifoHostPort
  import txp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMode16,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  input  logic              stsInValid,
  input  logic [WORD_W-1:0] stsInData,
  output logic              stsInReady,
  output logic              dataOutValid,
  output logic [WORD_W-1:0] dataOutData,
  input  logic              dataOutReady,
  output logic [LVL_W-1:0]  stsLevel,
  output logic [LVL_W-1:0]  dataLevel,
  output logic              overrunFlag
);
  ctrlStrobes_t strobes;

  txpCtrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk, .rstN, .busMode16, .hostAddr, .hostWr, .hostRd, .hostWrData,
    .strobes(strobes)
  );

  txpDatapath #(.DEPTH(FIFO_DEPTH)) datapath (
    .clk, .rstN,
    .strobes     (strobes),
    .stsInValid, .stsInData, .stsInReady,
    .dataOutValid, .dataOutData, .dataOutReady,
    .stsLevel, .dataLevel, .overrunFlag, .hostRdData
  );
endmodule

// File: tb/txFifoHostPort_test.sv
`timescale 1ns/1ps
module txFifoHostPort_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, busMode16, hostWr, hostRd, stsInValid, dataOutReady;
  logic [7:0] hostAddr;
  logic [31:0] hostWrData, hostRdData, stsInData, dataOutData;
  logic stsInReady, dataOutValid, overrunFlag;
  logic [4:0] stsLevel, dataLevel;

  txFifoHostPort uut (
    .clk, .rstN, .busMode16, .hostAddr, .hostWr, .hostRd, .hostWrData, .hostRdData,
    .stsInValid, .stsInData, .stsInReady, .dataOutValid, .dataOutData, .dataOutReady,
    .stsLevel, .dataLevel, .overrunFlag
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] dq[$];
  logic [31:0] sq[$];
  bit mOvr = 0;
  bit mPend = 0;
  logic [15:0] mLow = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] readModel(input logic [7:0] a);
    case (a[7:2])
      6'h10, 6'h11: return (sq.size() > 0) ? sq[0] : 32'h0;
      6'h19:        return 32'h8765_4321;
      default:      return 32'h0;
    endcase
  endfunction

  function automatic string readTag(input logic [7:0] a);
    if ((a[7:2] == 6'h10 || a[7:2] == 6'h11) && sq.size() == 0) return "R4 empty read";
    case (a[7:2])
      6'h10:   return "R2 pop read";
      6'h11:   return "R3 peek read";
      6'h19:   return "R7 byte test";
      default: return "R10 zero read";
    endcase
  endfunction

  task automatic step(input bit wr, input bit rd, input logic [7:0] addr, input logic [31:0] wd,
                      input bit sv, input logic [31:0] sd, input bit rdy);
    logic [31:0] expRd, pw;
    bit doDPop, doDPush, doSPop, doSPush;
    string rt;
    hostWr = wr; hostRd = rd; hostAddr = addr; hostWrData = wd;
    stsInValid = sv; stsInData = sd; dataOutReady = rdy;
    pw = '0;
    doDPop = rdy && dq.size() > 0;
    doDPush = 0;
    if (wr && addr >= 8'h20 && addr <= 8'h3F) begin
      if (busMode16) begin
        if (!mPend) begin mLow = wd[15:0]; mPend = 1; end
        else begin pw = {wd[15:0], mLow}; mPend = 0; doDPush = 1; end
      end else begin
        pw = wd; mPend = 0; doDPush = 1;
      end
    end
    if (doDPush && dq.size() >= DEPTH) begin mOvr = 1; doDPush = 0; end
    expRd = readModel(addr);
    rt = readTag(addr);
    doSPop = rd && addr[7:2] == 6'h10 && sq.size() > 0;
    doSPush = sv && sq.size() < DEPTH;
    @(posedge clk);
    if (doDPop) void'(dq.pop_front());
    if (doDPush) dq.push_back(pw);
    if (doSPop) void'(sq.pop_front());
    if (doSPush) sq.push_back(sd);
    @(negedge clk);
    hostWr = 0; hostRd = 0; stsInValid = 0; dataOutReady = 0;
    if (rd) chk(rt, hostRdData, expRd);
    chk("R9 status level", 32'(stsLevel), 32'(sq.size()));
    chk("R9 data level", 32'(dataLevel), 32'(dq.size()));
    chk("R9 status ready", 32'(stsInReady), 32'(sq.size() < DEPTH));
    chk("R11 data valid", 32'(dataOutValid), 32'(dq.size() > 0));
    if (dq.size() > 0) chk(busMode16 ? "R6 data head" : "R5 data head", dataOutData, dq[0]);
    chk("R8 overrun flag", 32'(overrunFlag), 32'(mOvr));
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d); step(1, 0, a, d, 0, 0, 0); endtask
  task automatic hrd(input logic [7:0] a); step(0, 1, a, 0, 0, 0, 0); endtask
  task automatic spush(input logic [31:0] d); step(0, 0, 0, 0, 1, d, 0); endtask
  task automatic drain(); step(0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    #(8ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 0; busMode16 = 0; hostWr = 0; hostRd = 0; hostAddr = 0; hostWrData = 0;
    stsInValid = 0; stsInData = 0; dataOutReady = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status level", 32'(stsLevel), 0);
    chk("R1 data level", 32'(dataLevel), 0);
    chk("R1 overrun", 32'(overrunFlag), 0);
    chk("R1 read data", hostRdData, 0);
    chk("R1 data valid", 32'(dataOutValid), 0);
    chk("R1 status ready", 32'(stsInReady), 1);

    // R5 window edges and unaligned addresses
    hwr(8'h20, 32'hA000_0001);
    hwr(8'h3C, 32'hA000_0002);
    hwr(8'h2D, 32'hA000_0003);
    hwr(8'h3F, 32'hA000_0004);
    hwr(8'h1F, 32'hDEAD_0000);   // R10 outside the window
    hwr(8'h40, 32'hDEAD_0001);   // R10 status pop port write ignored
    hwr(8'h44, 32'hDEAD_0002);   // R10 peek port write ignored
    hwr(8'h64, 32'hDEAD_0003);   // R10 test register write ignored
    hrd(8'h64);                  // R7 still constant
    hrd(8'h24);                  // R10 window reads zero
    // R8 fill beyond 16
    for (int i = 0; i < 14; i++) hwr(8'h20 + 8'(4 * (i % 8)), 32'hB000_0000 + 32'(i));
    drain();
    repeat (20) drain();         // R11 drain in order

    // R4 empty status reads
    hrd(8'h40);
    hrd(8'h44);
    // R3 and R2 ordering
    spush(32'h5000_0011);
    spush(32'h5000_0022);
    spush(32'h5000_0033);
    hrd(8'h44);
    hrd(8'h44);
    hrd(8'h40);
    hrd(8'h44);
    hrd(8'h40);
    hrd(8'h40);
    hrd(8'h40);
    // R9 status full
    for (int i = 0; i < 18; i++) spush(32'h6000_0000 + 32'(i));
    for (int i = 0; i < 17; i++) hrd(8'h40);

    // R6 half-word pairing
    busMode16 = 1;
    hwr(8'h20, 32'hFFFF_1234);
    hwr(8'h22, 32'hFFFF_ABCD);
    hwr(8'h3E, 32'h0000_5678);
    hwr(8'h30, 32'h0000_9ABC);
    hwr(8'h24, 32'h0000_1111);   // lone half
    busMode16 = 0;
    hwr(8'h28, 32'h7777_7777);   // R6 pending half discarded
    repeat (6) drain();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [7:0] a;
      sel = int'($urandom % 6);
      case (sel)
        0, 1: a = 8'h20 + 8'($urandom % 32);
        2: a = 8'h40;
        3: a = 8'h44;
        4: a = 8'h64;
        default: a = 8'($urandom);
      endcase
      if ($urandom % 64 == 0) busMode16 = ~busMode16;
      step(($urandom % 2) == 1, ($urandom % 3) == 0, a, $urandom,
           ($urandom % 3) == 0, $urandom, ($urandom % 4) == 0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule